// File: doc/BRIEF.md
# Write-Once Software Watchdog Timer

This block is a system-protection watchdog that sits on a simple register bus. It has two registers. The control register sets whether the watchdog runs, what an expiry does, and which of four timeout lengths applies. The service register restarts the timeout. Software gets a single chance to program the control register after reset. From then on the register is locked, so errant code cannot switch the watchdog off or change its period.

While the watchdog runs, a prescaler divides the clock into ticks. A down-counter counts those ticks. Software restarts both by writing two key bytes to the service register in order: first 0x55, then 0xAA. A periodic source, such as a timer tick handler, normally performs this write pair. If the counter runs out, the block does one of two things, chosen by the control register. In reset mode it emits a one-cycle system reset request. In interrupt mode it raises a level interrupt that stays high until the next valid service.

Top module: `wdog_top`

## Requirements
- R1: After reset, the control register reads 0x00, the watchdog is disabled, and both `rst_req` and `irq` are low.
- R2: The first write to the control register (address 0) after reset is latched. A read of address 0 returns the latched byte in the cycle after the read. The control fields are: bit 7 enables the watchdog, bit 6 selects reset mode (1) or interrupt mode (0), and bits 5:4 select the timeout.
- R3: Every control write after the first is ignored. Readback and behaviour stay unchanged.
- R4: Timeout select value s gives N = 2^(BASE_LOG2 + STEP_LOG2*s) ticks of 2^PRESC_LOG2 cycles each. When counting starts from a control write at edge E, the expiry registers at edge E + 1 + N*2^PRESC_LOG2.
- R5: A write of 0x55 to the service register (address 1), followed by a write of 0xAA, restarts the count at the 0xAA write edge K. The next expiry then comes at edge K + N*2^PRESC_LOG2.
- R6: The following service writes do not restart the count, and each clears any pending 0x55: 0xAA with no pending 0x55, or any value other than 0x55 or 0xAA.
- R7: Bus cycles that do not write the service register do not break a pending 0x55. This covers reads, control writes and writes to other addresses.
- R8: While bit 7 of the control register is 0, neither `rst_req` nor `irq` is ever asserted.
- R9: In reset mode, an expiry gives a `rst_req` pulse exactly one cycle wide. The count then reloads, and with no service it expires again one full period later.
- R10: In interrupt mode, an expiry sets `irq`. It stays high until a valid 0x55/0xAA sequence and falls in the cycle after the 0xAA write.
- R11: A read of the service register returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus cycle select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address (0 control, 1 service) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rst_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | Interrupt level, held until serviced |

## Verification
Some internal faults show up at the ports only late. A prescaler or counter that is off by one moves the expiry edge by a whole tick or by a single cycle. The bench therefore checks the cycle just before, at and just after each predicted expiry. A sequence checker that keeps a stale 0x55 state, or that drops it on unrelated bus cycles, is visible only one full period after the service attempt. Each case is timed against both the old and the new restart point. A lock flag that fails to set shows up at once on the next control readback.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef struct packed {
    logic       en;
    logic       rst_mode;
    logic [1:0] sel;
    logic [3:0] spare;
  } wdog_ctrl_t;

  localparam logic [7:0] SVC_KEY_ARM  = 8'h55;
  localparam logic [7:0] SVC_KEY_FIRE = 8'hAA;
endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_stb,
  input  logic [7:0] wdata,
  output wdog_ctrl_t ctrl_q,
  output logic       locked_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      locked_q <= 1'b0;
    end else if (wr_stb && !locked_q) begin
      ctrl_q   <= wdog_ctrl_t'(wdata);
      locked_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog_svc_seq.sv
module wdog_svc_seq
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_stb,
  input  logic [7:0] wdata,
  output logic       kick
);
  logic armed_q;

  assign kick = wr_stb && armed_q && (wdata == SVC_KEY_FIRE);

  always_ff @(posedge clk) begin
    if (rst)         armed_q <= 1'b0;
    else if (wr_stb) armed_q <= (wdata == SVC_KEY_ARM);
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int PRESC_LOG2 = 14,
  parameter int BASE_LOG2  = 9,
  parameter int STEP_LOG2  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [1:0] sel,
  input  logic       kick,
  output logic       expire
);
  localparam int NSEL  = 4;
  localparam int CNT_W = BASE_LOG2 + STEP_LOG2 * (NSEL - 1) + 1;

  logic [CNT_W-1:0]      reload_tab [NSEL];
  logic [PRESC_LOG2-1:0] presc_q;
  logic [CNT_W-1:0]      count_q;
  logic                  run_q;
  logic                  tick;

  for (genvar g = 0; g < NSEL; g++) begin : g_reload
    assign reload_tab[g] = CNT_W'(1) << (BASE_LOG2 + STEP_LOG2 * g);
  end

  assign tick   = &presc_q;
  assign expire = run_q && !kick && tick && (count_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      presc_q <= '0;
      count_q <= '0;
      run_q   <= 1'b0;
    end else begin
      run_q <= en;
      if (!run_q || kick) begin
        presc_q <= '0;
        count_q <= reload_tab[sel];
      end else begin
        presc_q <= presc_q + 1'b1;
        if (tick) begin
          if (count_q == CNT_W'(1)) count_q <= reload_tab[sel];
          else                      count_q <= count_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int ADDR_W     = 2,
  parameter int PRESC_LOG2 = 14,
  parameter int BASE_LOG2  = 9,
  parameter int STEP_LOG2  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              rst_req,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] SVC_ADDR  = ADDR_W'(1);

  wdog_ctrl_t ctrl_q;
  logic       ctrl_locked;
  logic       ctrl_wr, svc_wr, ctrl_rd, svc_rd;
  logic       kick, expire;

  assign ctrl_wr = bus_sel &&  bus_wr && (bus_addr == CTRL_ADDR);
  assign svc_wr  = bus_sel &&  bus_wr && (bus_addr == SVC_ADDR);
  assign ctrl_rd = bus_sel && !bus_wr && (bus_addr == CTRL_ADDR);
  assign svc_rd  = bus_sel && !bus_wr && (bus_addr == SVC_ADDR);

  wdog_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst), .wr_stb(ctrl_wr), .wdata(bus_wdata),
    .ctrl_q(ctrl_q), .locked_q(ctrl_locked)
  );

  wdog_svc_seq u_svc (
    .clk(clk), .rst(rst), .wr_stb(svc_wr), .wdata(bus_wdata), .kick(kick)
  );

  wdog_counter #(
    .PRESC_LOG2(PRESC_LOG2), .BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2)
  ) u_cnt (
    .clk(clk), .rst(rst), .en(ctrl_q.en), .sel(ctrl_q.sel),
    .kick(kick), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      rst_req   <= 1'b0;
      irq       <= 1'b0;
    end else begin
      bus_rdata <= ctrl_rd ? ctrl_q : 8'h00;
      rst_req   <= expire && ctrl_q.rst_mode;
      if (kick)                             irq <= 1'b0;
      else if (expire && !ctrl_q.rst_mode)  irq <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker (
  input logic       clk,
  input logic       rst,
  input logic       rst_req,
  input logic       irq,
  input logic       kick,
  input logic       locked,
  input logic [7:0] ctrl,
  input logic       svc_rd,
  input logic [7:0] rdata
);
  a_r3_lock_holds: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(ctrl));
  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !ctrl[7] |-> (!rst_req && !irq));
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);
  a_r9_reset_mode_only: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> ctrl[6]);
  a_r10_irq_mode_only: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> !ctrl[6]);
  a_r10_irq_held: assert property (@(posedge clk) disable iff (rst)
    (irq && !kick) |=> irq);
  a_r10_irq_cleared: assert property (@(posedge clk) disable iff (rst)
    kick |=> !irq);
  a_r11_svc_reads_zero: assert property (@(posedge clk) disable iff (rst)
    svc_rd |=> (rdata == 8'h00));
endmodule

bind wdog_top wdog_checker u_chk (
  .clk(clk), .rst(rst), .rst_req(rst_req), .irq(irq), .kick(kick),
  .locked(ctrl_locked), .ctrl(ctrl_q), .svc_rd(svc_rd), .rdata(bus_rdata)
);

// File: tb/test_wdog_top.sv
`timescale 1ns/1ps
module test_wdog_top;
  localparam int P = 2, B = 3, S = 2;
  localparam int M0 = (1 << B) << P;        // sel0 period in cycles: 32
  localparam int M1 = (1 << (B + S)) << P;  // sel1 period: 128

  logic clk = 1'b0, rst = 1'b1;
  logic bus_sel = 0, bus_wr = 0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic rst_req, irq;
  int checks = 0, fails = 0, cyc = 0, last_edge = 0, pulses = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_req) pulses <= pulses + 1;

  wdog_top #(.ADDR_W(2), .PRESC_LOG2(P), .BASE_LOG2(B), .STEP_LOG2(S)) i_wdog_top (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
    last_edge = cyc;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic wait_edge(input int e);
    while (cyc < e) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    do_reset();
    chk("R1 rst_req", rst_req, 0);
    chk("R1 irq", irq, 0);
    rd(2'd0, d); chk("R1 ctrl readback", d, 8'h00);
    rd(2'd1, d); chk("R11 service read", d, 8'h00);
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    int p0;
    do_reset();
    p0 = pulses;
    wr(2'd0, 8'h30);
    wr(2'd0, 8'hC0);
    rd(2'd0, d); chk("R3 second write ignored", d, 8'h30);
    repeat (3000) @(negedge clk);
    chk("R8 no reset pulse while disabled", pulses - p0, 0);
    chk("R8 no irq while disabled", irq, 0);
  endtask

  task automatic t_reset_mode();
    int x;
    do_reset();
    wr(2'd0, 8'hC0);
    x = last_edge + 1 + M0;
    wait_edge(x - 1); chk("R4 no early expiry sel0", rst_req, 0);
    wait_edge(x);     chk("R4 expiry sel0", rst_req, 1);
    wait_edge(x + 1); chk("R9 pulse one cycle", rst_req, 0);
    wait_edge(x + M0 - 1); chk("R9 reload no early", rst_req, 0);
    wait_edge(x + M0);     chk("R9 second expiry", rst_req, 1);
    chk("R9 irq unused in reset mode", irq, 0);
  endtask

  task automatic t_irq_mode();
    logic [7:0] d;
    int x;
    do_reset();
    wr(2'd0, 8'h90);
    x = last_edge + 1 + M1;
    rd(2'd0, d); chk("R2 ctrl latched", d, 8'h90);
    wait_edge(x - 1); chk("R4 no early expiry sel1", irq, 0);
    wait_edge(x);     chk("R10 irq set", irq, 1);
    chk("R10 no reset pulse", rst_req, 0);
    repeat (200) @(negedge clk);
    chk("R10 irq held", irq, 1);
    wr(2'd1, 8'h55);
    chk("R10 still held after 0x55", irq, 1);
    wr(2'd1, 8'hAA);
    chk("R10 irq cleared by service", irq, 0);
  endtask

  task automatic t_periodic_service();
    int p0, k;
    do_reset();
    wr(2'd0, 8'hC0);
    p0 = pulses;
    for (int i = 0; i < 10; i++) begin
      repeat (20) @(negedge clk);
      wr(2'd1, 8'h55);
      wr(2'd1, 8'hAA);
    end
    chk("R5 periodic service prevents expiry", pulses - p0, 0);
    k = last_edge;
    wait_edge(k + M0 - 1); chk("R5 restart no early", rst_req, 0);
    wait_edge(k + M0);     chk("R5 expiry after restart", rst_req, 1);
  endtask

  task automatic t_broken_seq();
    int x;
    do_reset();
    wr(2'd0, 8'hC0);
    x = last_edge + 1 + M0;
    wr(2'd1, 8'hAA);
    wr(2'd1, 8'h55); wr(2'd1, 8'h12); wr(2'd1, 8'hAA);
    wr(2'd1, 8'h55); wr(2'd1, 8'h55); wr(2'd1, 8'h00);
    wait_edge(x - 1); chk("R6 no restart before", rst_req, 0);
    wait_edge(x);     chk("R6 bad sequences did not restart", rst_req, 1);
  endtask

  task automatic t_interleaved();
    logic [7:0] d;
    int x0, k;
    do_reset();
    wr(2'd0, 8'hC0);
    x0 = last_edge + 1 + M0;
    wr(2'd1, 8'h55);
    rd(2'd0, d);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h33);
    rd(2'd1, d);
    wr(2'd1, 8'hAA);
    k = last_edge;
    wait_edge(x0); chk("R7 original expiry suppressed", rst_req, 0);
    wait_edge(k + M0 - 1); chk("R7 no early", rst_req, 0);
    wait_edge(k + M0);     chk("R7 restart held across other cycles", rst_req, 1);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset_state();
    t_disabled();
    t_reset_mode();
    t_irq_mode();
    t_periodic_service();
    t_broken_seq();
    t_interleaved();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule